// File: doc/BRIEF.md
# Runtime Mode Register Update Gate

This block sits beside a DRAM command scheduler and handles a request to rewrite one mode register while the memory is in normal operation. The scheduler presents a register index and a value. The gate accepts the request, raises `busy` and holds the write back until the device is idle. The device is idle when every bank is closed, the precharge recovery time has run out, no data burst is in flight and clock enable is high. The gate then places a single mode-register-set command on its command outputs.

Termination control passes through the gate. While it is idle, `odt_out` follows the scheduler's `odt_req`. From the cycle after acceptance until the settle time after the write has expired, `odt_out` is forced low. This keeps termination off before the command and keeps it off until the new setting has taken effect. A second request that arrives while the gate is busy is not accepted. The gate takes it once `busy` has fallen.

Top module: `mode_reg_update_gate`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `req_ready` is 1, `cmd_valid` is 0 and `cmd_cs_n` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `busy` is 1 and `req_ready` is 0 until the gate returns to idle. A request that stays asserted meanwhile is accepted only after that.
- R3: No command is issued while any bit of `bank_open` is 1. With all other conditions met, the command appears in the cycle after the last bank closes.
- R4: The command appears no earlier than TRP+1 cycles after a cycle with `pre_cmd` high. With all other conditions met, it appears exactly then.
- R5: No command is issued while `burst_active` is 1. The command follows one cycle after the burst ends.
- R6: No command is issued while `cke_high` is 0. The command follows one cycle after clock enable returns high.
- R7: The command lasts one cycle with `cmd_valid` 1 and chip select, row strobe, column strobe and write enable all 0. `cmd_ba` is the 2-bit index zero-extended to 3 bits. `cmd_addr[12:0]` is the value and `cmd_addr[15:13]` is 0.
- R8: With no blocking condition, the command appears two cycles after the acceptance edge. `odt_out` equals `odt_req` in the acceptance cycle and is 0 from the next cycle onward.
- R9: `busy` stays 1 and `odt_out` stays 0 for TMOD-1 cycles after the command cycle. In the TMOD-th cycle after it, `busy` is 0 and `odt_out` follows `odt_req` again.
- R10: Outside the command cycle the command outputs carry a deselect: `cmd_cs_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` are 1, and `cmd_ba` and `cmd_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Update request present |
| req_sel | input | 2 | Target mode register index |
| req_value | input | 13 | Value to write |
| req_ready | output | 1 | Gate can accept a request |
| busy | output | 1 | Update in progress; scheduler must issue nothing else |
| bank_open | input | 8 | One bit per bank, 1 while the bank is active |
| pre_cmd | input | 1 | A precharge is issued this cycle |
| burst_active | input | 1 | A read or write burst is in flight |
| cke_high | input | 1 | Clock enable is currently high |
| odt_req | input | 1 | Termination level wanted by the scheduler |
| odt_out | output | 1 | Termination level toward the device |
| cmd_valid | output | 1 | Mode-register-set command on the bus this cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 3 | Bank address, selects the register |
| cmd_addr | output | 16 | Address bus, carries the value |

## Verification
The gate is driven with a request that meets no obstacle and with requests held back by each blocking condition alone: an open bank, a burst in flight, clock enable low, and a recent precharge. The release point is varied for each. The command latency measured from acceptance differs for each case, which shows that each condition gates the write on its own and that the precharge recovery counts from the precharge cycle. The command fields, the length of the busy and termination-off window, and the deselect afterwards are checked for every request. A directed back-to-back case keeps a request asserted through a whole update to show that it is held off until the gate is idle.

// File: rtl/mrug_pkg.sv
// Package: shared state type for the mode register update gate.
// Assumes nothing beyond the enclosing design's clock domain.
package mrug_pkg;

    // Phases of one runtime mode register update.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // waiting for a request
        PH_HOLD   = 2'd1,  // accepted, termination off, waiting for idle device
        PH_ISSUE  = 2'd2,  // command on the bus this cycle
        PH_SETTLE = 2'd3   // counting out the settle time
    } mrug_phase_e;

endpackage

// File: rtl/mrug_trp_tracker.sv
// Tracks how long ago the last precharge was issued and reports when the
// precharge recovery time of TRP cycles has passed.
// Assumes pre_cmd is a one-cycle pulse per precharge command; TRP >= 1.
module mrug_trp_tracker #(
    parameter int TRP = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_cmd,
    output logic trp_ok
);
    localparam int CW = $clog2(TRP + 1);

    logic [CW-1:0] since_pre;

    // Saturating count of cycles since the last precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_pre <= CW'(TRP);
        else if (pre_cmd)
            since_pre <= CW'(1);
        else if (since_pre < CW'(TRP))
            since_pre <= since_pre + 1'b1;
    end

    assign trp_ok = (since_pre >= CW'(TRP)) && !pre_cmd;

    // R4: recovery is never reported in the cycle right after a precharge.
    a_r4_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((TRP > 1) && $past(pre_cmd)) |-> !trp_ok);

endmodule

// File: rtl/mrug_cmd_encoder.sv
// Drives the command bus: a mode-register-set in the fire cycle, a deselect
// in all other cycles. Reserved upper address bits are written as zero.
// Assumes ADDR_W >= VAL_W and BA_W >= SEL_W.
module mrug_cmd_encoder #(
    parameter int SEL_W  = 2,
    parameter int VAL_W  = 13,
    parameter int BA_W   = 3,
    parameter int ADDR_W = 16
) (
    input  logic              fire,
    input  logic [SEL_W-1:0]  sel,
    input  logic [VAL_W-1:0]  value,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    // Pick between the register write encoding and a deselect.
    always_comb begin
        cs_n  = !fire;
        ras_n = !fire;
        cas_n = !fire;
        we_n  = !fire;
        ba    = fire ? BA_W'(sel)     : '0;
        addr  = fire ? ADDR_W'(value) : '0;
    end

endmodule

// File: rtl/mode_reg_update_gate.sv
// Accepts one mode register rewrite request during normal operation. It
// holds the request until all banks are closed, the precharge recovery
// has passed, no burst runs and clock enable is high. It then issues the
// write and keeps termination off until TMOD cycles after it.
// Assumes the scheduler issues no command while busy is high; TMOD >= 2.
module mode_reg_update_gate
    import mrug_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int SEL_W  = 2,
    parameter int VAL_W  = 13,
    parameter int BA_W   = 3,
    parameter int ADDR_W = 16,
    parameter int TRP    = 6,
    parameter int TMOD   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [VAL_W-1:0]  req_value,
    output logic              req_ready,
    output logic              busy,
    input  logic [NBANK-1:0]  bank_open,
    input  logic              pre_cmd,
    input  logic              burst_active,
    input  logic              cke_high,
    input  logic              odt_req,
    output logic              odt_out,
    output logic              cmd_valid,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int MW = $clog2(TMOD + 1);

    mrug_phase_e      phase, phase_nx;
    logic [MW-1:0]    settle_cnt;
    logic [SEL_W-1:0] held_sel;
    logic [VAL_W-1:0] held_value;
    logic             trp_ok;
    logic             dev_idle;
    logic             settle_done;

    mrug_trp_tracker #(.TRP(TRP)) trp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pre_cmd(pre_cmd),
        .trp_ok (trp_ok)
    );

    // Combined idle check the write must wait for.
    assign dev_idle    = (bank_open == '0) && trp_ok && !burst_active && cke_high;
    assign settle_done = (settle_cnt == MW'(TMOD - 1));

    // Next phase of the update sequence.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:   if (req_valid)   phase_nx = PH_HOLD;
            PH_HOLD:   if (dev_idle)    phase_nx = PH_ISSUE;
            PH_ISSUE:                   phase_nx = PH_SETTLE;
            PH_SETTLE: if (settle_done) phase_nx = PH_IDLE;
            default:                    phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Cycles elapsed since the command, counted through the settle phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                 settle_cnt <= '0;
        else if (phase == PH_ISSUE) settle_cnt <= MW'(1);
        else if (phase == PH_SETTLE && !settle_done)
            settle_cnt <= settle_cnt + 1'b1;
    end

    // Capture the target register and value when the request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_sel   <= '0;
            held_value <= '0;
        end else if (phase == PH_IDLE && req_valid) begin
            held_sel   <= req_sel;
            held_value <= req_value;
        end
    end

    assign req_ready = (phase == PH_IDLE);
    assign busy      = (phase != PH_IDLE);
    assign odt_out   = odt_req && (phase == PH_IDLE);
    assign cmd_valid = (phase == PH_ISSUE);

    mrug_cmd_encoder #(
        .SEL_W(SEL_W), .VAL_W(VAL_W), .BA_W(BA_W), .ADDR_W(ADDR_W)
    ) enc_i (
        .fire (cmd_valid),
        .sel  (held_sel),
        .value(held_value),
        .cs_n (cmd_cs_n),
        .ras_n(cmd_ras_n),
        .cas_n(cmd_cas_n),
        .we_n (cmd_we_n),
        .ba   (cmd_ba),
        .addr (cmd_addr)
    );

    // R3: a command follows only a cycle with every bank closed.
    a_r3_banks_closed: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(bank_open) == '0));

    // R5: no command right after a cycle with a burst in flight.
    a_r5_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(burst_active));

    // R6: clock enable was high in the cycle before the command.
    a_r6_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(cke_high));

    // R7: the command occupies exactly one cycle.
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8: termination was already off in the cycle before the command.
    a_r8_odt_off_before: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(odt_out));

    // R2: busy only rises after a request was presented.
    a_r2_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R9: the gate never goes idle directly from the command cycle.
    a_r9_settle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> busy);

endmodule

// File: tb/mode_reg_update_gate_tb_top.sv
module mode_reg_update_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TRP  = 6;
    localparam int TMOD = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [12:0] req_value = '0;
    logic        req_ready, busy;
    logic [7:0]  bank_open = '0;
    logic        pre_cmd = 1'b0;
    logic        burst_active = 1'b0;
    logic        cke_high = 1'b1;
    logic        odt_req = 1'b1;
    logic        odt_out, cmd_valid, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [2:0]  cmd_ba;
    logic [15:0] cmd_addr;

    int n_vec  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_reg_update_gate #(.TRP(TRP), .TMOD(TMOD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_sel(req_sel), .req_value(req_value),
        .req_ready(req_ready), .busy(busy),
        .bank_open(bank_open), .pre_cmd(pre_cmd),
        .burst_active(burst_active), .cke_high(cke_high),
        .odt_req(odt_req), .odt_out(odt_out),
        .cmd_valid(cmd_valid), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
        .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
    );

    // Vector: {blocker kind[2:0], release point[7:0], sel[1:0], value[12:0]}
    // kinds: 0 none, 1 open bank, 2 burst, 3 cke low, 4 open bank + precharge
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {3'd0, 8'd0, 2'd0, 13'h0520},
        {3'd1, 8'd3, 2'd1, 13'h0044},
        {3'd2, 8'd5, 2'd2, 13'h0008},
        {3'd3, 8'd4, 2'd3, 13'h1FFF},
        {3'd4, 8'd2, 2'd0, 13'h1ABC},
        {3'd1, 8'd1, 2'd2, 13'h0001}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    // Checks the command fields, the settle window and the deselect after it.
    task automatic check_cmd_and_settle(input logic [1:0] sel, input logic [12:0] val);
        check(cmd_cs_n == 0 && cmd_ras_n == 0 && cmd_cas_n == 0 && cmd_we_n == 0,
              "R7 strobes", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 0);
        check(cmd_ba == {1'b0, sel}, "R7 bank field", cmd_ba, {1'b0, sel});
        check(cmd_addr == {3'b000, val}, "R7 addr field", cmd_addr, {3'b000, val});
        for (int m = 1; m <= TMOD; m++) begin
            @(negedge clk);
            if (m == 1)
                check(cmd_valid == 0, "R7 single cycle", cmd_valid, 0);
            if (m == TMOD - 1)
                check(busy == 1 && odt_out == 0, "R9 still settling", {busy, odt_out}, 2'b10);
            if (m == TMOD) begin
                check(busy == 0 && odt_out == odt_req, "R9 settle end", {busy, odt_out}, {1'b0, odt_req});
                check(cmd_cs_n == 1 && cmd_we_n == 1 && cmd_ba == 0 && cmd_addr == 0,
                      "R10 deselect", {cmd_cs_n, cmd_we_n, cmd_addr}, {2'b11, 16'h0});
            end
        end
    endtask

    task automatic run_vector(input logic [25:0] v);
        int kind = int'(v[25:23]);
        int rel  = int'(v[22:15]);
        int exp_n;
        int got = -1;
        @(negedge clk);
        bank_open    = (kind == 1 || kind == 4) ? 8'h05 : 8'h00;
        burst_active = (kind == 2);
        cke_high     = (kind != 3);
        req_sel      = v[14:13];
        req_value    = v[12:0];
        req_valid    = 1'b1;
        #1;
        check(req_ready == 1, "R2 ready when idle", req_ready, 1);
        check(odt_out == 1, "R8 odt follows when idle", odt_out, 1);
        case (kind)
            0:       exp_n = 2;
            4:       exp_n = rel + TRP + 1;
            default: exp_n = (rel + 1 > 2) ? rel + 1 : 2;
        endcase
        for (int n = 1; n <= 100 && got < 0; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (n == 1)
                check(busy == 1 && req_ready == 0 && odt_out == 0,
                      "R2/R8 busy and odt off", {busy, req_ready, odt_out}, 3'b100);
            if (cmd_valid) got = n;
            else begin
                if (kind == 4 && n == rel + 1) pre_cmd = 1'b0;
                if (n == rel) begin
                    if (kind == 4) begin bank_open = '0; pre_cmd = 1'b1; end
                    if (kind == 1) bank_open = '0;
                    if (kind == 2) burst_active = 1'b0;
                    if (kind == 3) cke_high = 1'b1;
                end
            end
        end
        case (kind)
            0: check(got == exp_n, "R8 latency", got, exp_n);
            1: check(got == exp_n, "R3 latency", got, exp_n);
            2: check(got == exp_n, "R5 latency", got, exp_n);
            3: check(got == exp_n, "R6 latency", got, exp_n);
            default: check(got == exp_n, "R4 latency", got, exp_n);
        endcase
        pre_cmd = 1'b0;
        if (got > 0) check_cmd_and_settle(v[14:13], v[12:0]);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(busy == 0 && req_ready == 1, "R1 reset handshake", {busy, req_ready}, 2'b01);
        check(cmd_valid == 0 && cmd_cs_n == 1, "R1 reset bus", {cmd_valid, cmd_cs_n}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_cs_n == 1 && cmd_ras_n == 1 && cmd_addr == 0, "R10 idle deselect",
              {cmd_cs_n, cmd_ras_n, cmd_addr}, {2'b11, 16'h0});

        for (int i = 0; i < NV; i++) run_vector(VEC[i]);

        // R2: a request held high through an update is taken only afterwards.
        @(negedge clk);
        bank_open = '0; burst_active = 0; cke_high = 1;
        req_sel = 2'd1; req_value = 13'h0111; req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(cmd_valid == 1 && cmd_ba == 3'd1, "R2 first command", {cmd_valid, cmd_ba}, 4'b1001);
        req_sel = 2'd2; req_value = 13'h0222;
        for (int m = 1; m <= TMOD; m++) begin
            @(negedge clk);
            if (m == TMOD - 1) check(req_ready == 0, "R2 held off while busy", req_ready, 0);
            if (m == TMOD)     check(req_ready == 1, "R2 ready after settle", req_ready, 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1, "R2 second accepted", busy, 1);
        @(negedge clk);
        check(cmd_valid == 1, "R2 second command", cmd_valid, 1);
        check_cmd_and_settle(2'd2, 13'h0222);

        // R1: reset in the middle of an update returns to idle.
        @(negedge clk);
        bank_open = 8'h80; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 0 && req_ready == 1, "R1 mid-update reset", {busy, req_ready}, 2'b01);

        done = 1'b1;
        finish_run();
    end

endmodule